// File: doc/BRIEF.md
# Single-Clock FIFO with Skewed Empty and Almost-Full Flags

This block is a first-in first-out buffer that runs on one clock. Writes and reads are requested with active-low strobes. Read data comes out through an output register that loads only when a read is accepted. A word that has just been written never passes straight through to the output.

The block drives two status flags, and their timing is deliberately uneven. The empty flag compares the read pointer with a copy of the write pointer that has been held back by one cycle. As a result, empty stays high one edge longer after a write into an empty buffer, but rises on the very edge that reads out the last word. The almost-full flag compares the true occupancy, taken from the undelayed pointers, against a threshold supplied on an input port. It changes on the same edge as the write or read that crosses the threshold, so a producer that stops writing as soon as it sees almost-full writes exactly the threshold number of words.

Storage is a plain behavioural array. Both pointers carry one extra wrap bit, so the occupancy is their modular difference.

Top module: `skew_flag_fifo`

## Requirements
- R1: A synchronous active-high reset clears the write pointer, the delayed write pointer and the read pointer. After the reset edge, `empty` is 1 and `almost_full` is 0.
- R2: A write is requested when `wr_n` is 0 at a rising edge, and a read is requested when `rd_n` is 0 at a rising edge. A value of 1 on either strobe requests nothing.
- R3: After a write into a buffer with zero occupancy, `empty` stays 1 after that write edge and falls only after the following edge.
- R4: A read that removes the last stored word, with no write on the same edge, makes `empty` 1 right after that same edge.
- R5: `almost_full` is 1 exactly when the occupancy (written minus read, modulo the pointer range) is at least `af_level`. It rises after the write edge that brings the occupancy up to `af_level`.
- R6: `almost_full` falls after the read edge that brings the occupancy below `af_level`, with no added delay.
- R7: On an accepted read, `rd_data` loads the oldest stored word at that edge, and words come out in write order. `rd_data` is undefined until the first accepted read.
- R8: A read requested while `empty` is 1 is ignored. The read pointer and `rd_data` do not change.
- R9: A write requested while the occupancy equals DEPTH is ignored. The occupancy never exceeds DEPTH, and the stored words are not overwritten.
- R10: The order of words is kept across pointer wrap-around during sustained simultaneous writing and reading.
- R11: With `af_level` = 32, a writer that attempts the values 0 to 34 but skips its write whenever `almost_full` is 1 stores only 0 to 31. Forty read attempts then return exactly 0 to 31 in order, and `empty` is 1 after 31 is read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| wr_n | input | 1 | Write request, active low |
| wr_data | input | WIDTH | Word to store |
| rd_n | input | 1 | Read request, active low |
| rd_data | output | WIDTH | Registered read word |
| af_level | input | $clog2(DEPTH)+1 | Almost-full threshold, in words |
| empty | output | 1 | Empty flag, uses the delayed write pointer |
| almost_full | output | 1 | Occupancy is at least af_level |

## Verification
Each result is due at a fixed edge. `rd_data` and `almost_full` reflect a read or write one edge after its request. `empty` reflects a read after one edge but a write only after two. The bench drives each request just after a rising edge. It samples one time unit after the next rising edge, where it compares the flags against a model. That model counts writes, reads and the write count delayed by one edge. A monitor pops the expected word from a queue two time units after each edge at which the model accepts a read, and it never compares `rd_data` before the first accepted read.

// File: rtl/skew_fifo_pkg.sv
package skew_fifo_pkg;
    localparam int DEF_DEPTH = 64;
    localparam int DEF_WIDTH = 16;
endpackage

// File: rtl/skew_fifo_flags.sv
module skew_fifo_flags #(
    parameter int DEPTH = skew_fifo_pkg::DEF_DEPTH,
    parameter int PW    = $clog2(DEPTH) + 1
) (
    input  logic [PW-1:0] wr_ptr,
    input  logic [PW-1:0] wr_ptr_late,
    input  logic [PW-1:0] rd_ptr,
    input  logic [PW-1:0] af_level,
    output logic [PW-1:0] occ,
    output logic          full,
    output logic          empty,
    output logic          almost_full
);
    localparam logic [PW-1:0] DEPTH_P = PW'(DEPTH);

    always_comb begin
        occ         = wr_ptr - rd_ptr;
        full        = (occ == DEPTH_P);
        empty       = (rd_ptr == wr_ptr_late);
        almost_full = (occ >= af_level);
    end
endmodule

// File: rtl/skew_fifo_ptrs.sv
module skew_fifo_ptrs #(
    parameter int DEPTH = skew_fifo_pkg::DEF_DEPTH,
    parameter int PW    = $clog2(DEPTH) + 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_req,
    input  logic          rd_req,
    input  logic          full,
    input  logic          empty,
    output logic          wr_acc,
    output logic          rd_acc,
    output logic [PW-1:0] wr_ptr,
    output logic [PW-1:0] wr_ptr_late,
    output logic [PW-1:0] rd_ptr
);
    typedef struct packed {
        logic [PW-1:0] wr;
        logic [PW-1:0] wr_late;
        logic [PW-1:0] rd;
    } ptr_state_t;

    ptr_state_t st_d, st_q;

    always_comb begin
        wr_acc = wr_req && !full;
        rd_acc = rd_req && !empty;
        st_d.wr_late = st_q.wr;
        st_d.wr      = st_q.wr + PW'(wr_acc);
        st_d.rd      = st_q.rd + PW'(rd_acc);
        if (rst) begin
            st_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign wr_ptr      = st_q.wr;
    assign wr_ptr_late = st_q.wr_late;
    assign rd_ptr      = st_q.rd;

    // R1: pointers are all zero on the cycle after reset
    assert_ptr_reset_R1: assert property (@(posedge clk)
        rst |=> (st_q.wr == '0 && st_q.rd == '0 && st_q.wr_late == '0));
endmodule

// File: rtl/skew_fifo_store.sv
module skew_fifo_store #(
    parameter int DEPTH = skew_fifo_pkg::DEF_DEPTH,
    parameter int WIDTH = skew_fifo_pkg::DEF_WIDTH,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             we,
    input  logic [AW-1:0]    waddr,
    input  logic [WIDTH-1:0] wdata,
    input  logic             re,
    input  logic [AW-1:0]    raddr,
    output logic [WIDTH-1:0] rdata
);
    logic [WIDTH-1:0] mem_q [DEPTH];
    logic [WIDTH-1:0] rdata_d, rdata_q;

    always_comb begin
        rdata_d = rdata_q;
        if (re) begin
            rdata_d = mem_q[raddr];
        end
    end

    always_ff @(posedge clk) begin
        if (we) begin
            mem_q[waddr] <= wdata;
        end
        rdata_q <= rdata_d;
    end

    assign rdata = rdata_q;
endmodule

// File: rtl/skew_flag_fifo.sv
module skew_flag_fifo #(
    parameter int DEPTH = skew_fifo_pkg::DEF_DEPTH,
    parameter int WIDTH = skew_fifo_pkg::DEF_WIDTH
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     wr_n,
    input  logic [WIDTH-1:0]         wr_data,
    input  logic                     rd_n,
    output logic [WIDTH-1:0]         rd_data,
    input  logic [$clog2(DEPTH):0]   af_level,
    output logic                     empty,
    output logic                     almost_full
);
    localparam int AW = $clog2(DEPTH);
    localparam int PW = AW + 1;
    localparam logic [PW-1:0] DEPTH_P = PW'(DEPTH);

    logic          wr_acc, rd_acc, full;
    logic [PW-1:0] wr_ptr, wr_ptr_late, rd_ptr, occ;

    initial begin
        assert (DEPTH == (1 << AW)) else $error("DEPTH must be a power of two");
    end

    skew_fifo_ptrs #(.DEPTH(DEPTH), .PW(PW)) u_ptrs (
        .clk         (clk),
        .rst         (rst),
        .wr_req      (!wr_n),
        .rd_req      (!rd_n),
        .full        (full),
        .empty       (empty),
        .wr_acc      (wr_acc),
        .rd_acc      (rd_acc),
        .wr_ptr      (wr_ptr),
        .wr_ptr_late (wr_ptr_late),
        .rd_ptr      (rd_ptr)
    );

    skew_fifo_flags #(.DEPTH(DEPTH), .PW(PW)) u_flags (
        .wr_ptr      (wr_ptr),
        .wr_ptr_late (wr_ptr_late),
        .rd_ptr      (rd_ptr),
        .af_level    (af_level),
        .occ         (occ),
        .full        (full),
        .empty       (empty),
        .almost_full (almost_full)
    );

    skew_fifo_store #(.DEPTH(DEPTH), .WIDTH(WIDTH), .AW(AW)) u_store (
        .clk   (clk),
        .we    (wr_acc),
        .waddr (wr_ptr[AW-1:0]),
        .wdata (wr_data),
        .re    (rd_acc),
        .raddr (rd_ptr[AW-1:0]),
        .rdata (rd_data)
    );

    // R1: flags after a reset edge
    assert_reset_flags_R1: assert property (@(posedge clk)
        rst |=> (empty && !almost_full));

    // R3: a write into a drained buffer leaves empty high for one more edge
    assert_empty_late_R3: assert property (@(posedge clk) disable iff (rst)
        (occ == '0 && wr_acc) |=> empty);

    // R4: reading the last word raises empty at once
    assert_empty_rise_R4: assert property (@(posedge clk) disable iff (rst)
        (rd_acc && !wr_acc && occ == PW'(1)) |=> empty);

    // R5: the write that reaches the threshold raises almost_full
    assert_af_rise_R5: assert property (@(posedge clk) disable iff (rst)
        (wr_acc && !rd_acc && (occ + PW'(1)) == af_level)
        |=> (almost_full || !$stable(af_level)));

    // R6: the read that drops below the threshold clears almost_full
    assert_af_fall_R6: assert property (@(posedge clk) disable iff (rst)
        (rd_acc && !wr_acc && occ == af_level && af_level != '0)
        |=> (!almost_full || !$stable(af_level)));

    // R8: a read on empty leaves the output register alone
    assert_rd_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (!rd_n && empty) |=> $stable(rd_data));

    // R9: occupancy bounded, and a full buffer without a read stays full
    assert_no_overflow_R9: assert property (@(posedge clk) disable iff (rst)
        occ <= DEPTH_P);
    assert_full_hold_R9: assert property (@(posedge clk) disable iff (rst)
        (occ == DEPTH_P && !rd_acc) |=> (occ == DEPTH_P));
endmodule

// File: tb/tb_skew_flag_fifo.sv
module tb_skew_flag_fifo;
    localparam int DEPTH = 64;
    localparam int WIDTH = 16;
    localparam int PW    = $clog2(DEPTH) + 1;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             wr_n = 1'b1;
    logic             rd_n = 1'b1;
    logic [WIDTH-1:0] wr_data = '0;
    logic [PW-1:0]    af_level = PW'(32);
    logic [WIDTH-1:0] rd_data;
    logic             empty, almost_full;

    skew_flag_fifo #(.DEPTH(DEPTH), .WIDTH(WIDTH)) dut (
        .clk(clk), .rst(rst), .wr_n(wr_n), .wr_data(wr_data), .rd_n(rd_n),
        .rd_data(rd_data), .af_level(af_level), .empty(empty),
        .almost_full(almost_full)
    );

    always #5 clk = ~clk;

    int n_tot = 0;
    int n_fail = 0;
    int wc = 0, wd = 0, rc = 0;   // model: writes, writes one edge late, reads
    int thr = 32;
    int n_pop = 0;
    int last_pop = -1;
    bit rd_exp = 1'b0;
    logic [WIDTH-1:0] exp_q [$];

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_tot++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // Driver: one cycle of stimulus, model update and flag checks
    task automatic cycle(input bit w, input int d, input bit r);
        bit wa, ra;
        wr_n    = !w;
        rd_n    = !r;
        wr_data = WIDTH'(d);
        wa = w && ((wc - rc) < DEPTH);
        ra = r && (rc != wd);
        if (wa) exp_q.push_back(WIDTH'(d));
        rd_exp = ra;
        @(posedge clk);
        #1;
        wd = wc;
        if (wa) wc++;
        if (ra) rc++;
        chk(empty == (rc == wd), "R3 R4 empty", int'(empty), int'(rc == wd));
        chk(almost_full == ((wc - rc) >= thr), "R5 R6 almost_full",
            int'(almost_full), int'((wc - rc) >= thr));
        wr_n = 1'b1;
        rd_n = 1'b1;
    endtask

    // Monitor: compares each accepted read against the scoreboard queue
    always @(posedge clk) begin
        bit take;
        int expv;
        take = rd_exp;
        #2;
        if (take) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R7 R2 data underflow", int'(rd_data), -1);
            end else begin
                expv = int'(exp_q.pop_front());
                chk(rd_data == WIDTH'(expv), "R7 R2 data", int'(rd_data), expv);
                n_pop++;
                last_pop = int'(rd_data);
            end
        end
    end

    initial begin
        #100000;
        n_tot++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_tot - n_fail, n_tot);
        $finish;
    end

    initial begin
        int base, nw;
        repeat (3) @(posedge clk);
        #1;
        rst = 1'b0;
        chk(empty == 1'b1, "R1 empty", int'(empty), 1);
        chk(almost_full == 1'b0, "R1 almost_full", int'(almost_full), 0);

        // R8: read on an empty buffer is ignored
        cycle(1'b0, 0, 1'b1);
        chk(empty == 1'b1, "R8 empty after ignored read", int'(empty), 1);

        // R11 sequence, writer gated by almost_full (threshold 32)
        thr = 32;
        af_level = PW'(32);
        base = n_pop;
        nw = 0;
        for (int i = 0; i < 35; i++) begin
            bit go;
            go = !almost_full;
            if (go) nw++;
            cycle(go, i, 1'b0);
            if (i == 0) chk(empty == 1'b1, "R3 empty held after first write", int'(empty), 1);
            if (i == 1) chk(empty == 1'b0, "R3 empty falls one edge later", int'(empty), 0);
            if (i == 30) chk(almost_full == 1'b0, "R5 below threshold", int'(almost_full), 0);
            if (i == 31) chk(almost_full == 1'b1, "R5 rises at 32nd word", int'(almost_full), 1);
        end
        chk(nw == 32, "R11 words written", nw, 32);
        for (int i = 0; i < 40; i++) begin
            cycle(1'b0, 0, 1'b1);
            if (i == 0) chk(almost_full == 1'b0, "R6 falls on first read", int'(almost_full), 0);
            if (i == 30) chk(empty == 1'b0, "R4 one word left", int'(empty), 0);
            if (i == 31) chk(empty == 1'b1, "R4 empty on last read", int'(empty), 1);
        end
        #3;
        chk((n_pop - base) == 32, "R11 words read", n_pop - base, 32);
        chk(last_pop == 31, "R11 last word", last_pop, 31);
        chk(empty == 1'b1, "R11 empty at end", int'(empty), 1);

        // R8: output holds through an ignored read
        cycle(1'b0, 0, 1'b1);
        #3;
        chk(rd_data == WIDTH'(31), "R8 rd_data held", int'(rd_data), 31);

        // R9: writes beyond DEPTH are dropped
        thr = DEPTH;
        af_level = PW'(DEPTH);
        base = n_pop;
        for (int i = 0; i < DEPTH + 6; i++) cycle(1'b1, 1000 + i, 1'b0);
        chk(almost_full == 1'b1, "R9 R5 full at DEPTH", int'(almost_full), 1);
        for (int i = 0; i < DEPTH + 2; i++) cycle(1'b0, 0, 1'b1);
        #3;
        chk((n_pop - base) == DEPTH, "R9 words kept", n_pop - base, DEPTH);
        chk(last_pop == 1000 + DEPTH - 1, "R9 last kept word", last_pop, 1000 + DEPTH - 1);

        // R10: streaming through pointer wrap
        thr = 4;
        af_level = PW'(4);
        base = n_pop;
        for (int i = 0; i < 3; i++) cycle(1'b1, 5000 + i, 1'b0);
        for (int i = 3; i < 203; i++) cycle(1'b1, 5000 + i, 1'b1);
        for (int i = 0; i < 6; i++) cycle(1'b0, 0, 1'b1);
        #3;
        chk((n_pop - base) == 203, "R10 words across wrap", n_pop - base, 203);
        chk(last_pop == 5202, "R10 last word", last_pop, 5202);
        chk(empty == 1'b1, "R10 drained", int'(empty), 1);

        $display("%0d/%0d checks passed", n_tot - n_fail, n_tot);
        $finish;
    end
endmodule